// File: doc/BRIEF.md
# Byte-Serial Load/Store Unit

This block carries out integer loads and stores against a small data memory that is one byte wide and byte addressed. A requester presents a 32-bit base value, a 12-bit signed offset, a three-bit width code, a direction bit and, for stores, a data word. The block forms the effective address. It then moves one byte per clock between the memory and an internal assembly register, lowest address first. When the last byte has moved, it pulses `done` for one cycle with the load result. Loads are sign- or zero-extended according to the width code.

Requests use a valid/ready handshake. `req_ready` is high only while the unit is idle. A request transfers on a rising edge where both `req_valid` and `req_ready` are high. While the unit is busy, `req_ready` stays low, and any `req_valid` it sees is neither stored nor acted on. The result side has no back-pressure: `result` is meaningful only in the single cycle that `done` is high, and the requester must take it then. The memory is an internal byte array. A combinational peek port lets a testbench read any byte at any time.

Top module: `lsu_byteserial`

## Requirements
- R1: The effective address is `req_base` plus `req_imm` sign-extended from bit 11, reduced modulo MEM_BYTES (a power of two). Accesses that run past the top address continue at address 0.
- R2: `req_ready` is 1 exactly when the unit is idle. A request is taken on an edge where `req_valid` and `req_ready` are both 1. `req_valid` asserted while `req_ready` is 0 writes no memory and produces no `done`.
- R3: An access of N bytes uses N consecutive cycles, with `mem_addr` rising by one each cycle. `done` is high for exactly one cycle, N cycles after the accepting edge.
- R4: A store (`req_store`=1) with width code 000, 001 or 010 writes 1, 2 or 4 bytes. The low byte of `req_wdata` goes to the effective address and each higher byte to the next address. No other byte changes.
- R5: A load with width code 010 returns the four bytes from the effective address upward, with the lowest address in bits 7:0.
- R6: A load with code 000 returns the byte with bit 7 copied into bits 31:8. A load with code 001 returns the halfword with bit 15 copied into bits 31:16.
- R7: A load with code 100 (byte) or 101 (halfword) fills the bits above the loaded data with zeros.
- R8: Width codes with no defined access are loads with 011, 110 or 111 and stores with any code above 010. They complete with N=0, so `done` comes in the cycle after acceptance. They return 0 and write no memory.
- R9: After reset, `req_ready`=1, `done`=0, `mem_we`=0 and every memory byte reads 0.
- R10: A store's `done` cycle shows `result`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_funct3 | input | 3 | Width/sign code |
| req_base | input | 32 | Base register value |
| req_imm | input | 12 | Signed offset |
| req_wdata | input | 32 | Store data |
| mem_addr | output | ADDR_W (6) | Byte address of the current transfer |
| mem_wdata | output | 8 | Byte being written |
| mem_we | output | 1 | Memory write enable for this cycle |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Extended load result, valid with done |
| peek_addr | input | ADDR_W (6) | Inspection read address |
| peek_data | output | 8 | Memory byte at peek_addr |

## Verification
For an access of N bytes, the result is due N clock edges after the accepting edge. That is 1, 2 or 4 edges for real accesses and 0 edges for undefined codes, which finish in the very next cycle. The driver queues each expected item before the accepting edge, tagged with the edge count at which it must arrive. The monitor samples on falling edges, and when `done` is high it compares both the value and the edge count. Memory effects are checked through the peek port only after the unit is idle again. At that point every write of the access has landed, as has any write that an ignored request could have caused.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } lsu_state_e;

  localparam logic [2:0] W_BYTE   = 3'b000;
  localparam logic [2:0] W_HALF   = 3'b001;
  localparam logic [2:0] W_WORD   = 3'b010;
  localparam logic [2:0] W_BYTE_U = 3'b100;
  localparam logic [2:0] W_HALF_U = 3'b101;

  // number of bytes an access moves; 0 marks an undefined code
  function automatic logic [2:0] access_len(input logic is_store, input logic [2:0] code);
    logic [2:0] n;
    n = 3'd0;
    if (is_store) begin
      case (code)
        W_BYTE:  n = 3'd1;
        W_HALF:  n = 3'd2;
        W_WORD:  n = 3'd4;
        default: n = 3'd0;
      endcase
    end else begin
      case (code)
        W_BYTE, W_BYTE_U: n = 3'd1;
        W_HALF, W_HALF_U: n = 3'd2;
        W_WORD:           n = 3'd4;
        default:          n = 3'd0;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int ADDR_W = 6,
  parameter int IMM_W  = 12,
  parameter int XLEN   = 32
) (
  input  logic [XLEN-1:0]   base,
  input  logic [IMM_W-1:0]  imm,
  output logic [ADDR_W-1:0] ea
);
  logic [XLEN-1:0] imm_x;
  logic [XLEN-1:0] sum;

  assign imm_x = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  assign sum   = base + imm_x;
  assign ea    = sum[ADDR_W-1:0];
endmodule

// File: rtl/lsu_mem.sv
module lsu_mem #(
  parameter int MEM_BYTES = 64,
  localparam int ADDR_W = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wbyte,
  output logic [7:0]        rbyte,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [7:0]        peek_data
);
  logic [7:0] bytes_q [MEM_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) bytes_q[i] <= 8'h00;
    end else if (we) begin
      bytes_q[addr] <= wbyte;
    end
  end

  assign rbyte     = bytes_q[addr];
  assign peek_data = bytes_q[peek_addr];
endmodule

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int XLEN   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [2:0]        req_funct3,
  input  logic [XLEN-1:0]   req_wdata,
  input  logic [ADDR_W-1:0] ea,
  output logic              req_ready,
  output logic              accept,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wbyte,
  output logic              cap,
  output logic [1:0]        cap_idx,
  output logic              done,
  output logic              store_q,
  output logic [2:0]        code_q,
  output logic [2:0]        len_q
);
  lsu_state_e        state_q;
  logic [ADDR_W-1:0] ea_q;
  logic [1:0]        idx_q;
  logic [XLEN-1:0]   wd_q;
  logic [2:0]        len_d;
  logic              last;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign len_d     = access_len(req_store, req_funct3);
  assign last      = ({1'b0, idx_q} == (len_q - 3'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ea_q    <= '0;
      idx_q   <= '0;
      wd_q    <= '0;
      store_q <= 1'b0;
      code_q  <= '0;
      len_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          ea_q    <= ea;
          idx_q   <= '0;
          wd_q    <= req_wdata;
          store_q <= req_store;
          code_q  <= req_funct3;
          len_q   <= len_d;
          state_q <= (len_d == 3'd0) ? ST_DONE : ST_BUSY;
        end
        ST_BUSY: begin
          if (last) state_q <= ST_DONE;
          else      idx_q   <= idx_q + 2'd1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr  = ea_q + ADDR_W'(idx_q);
  assign mem_we    = (state_q == ST_BUSY) && store_q;
  assign mem_wbyte = wd_q[idx_q*8 +: 8];
  assign cap       = (state_q == ST_BUSY) && !store_q;
  assign cap_idx   = idx_q;
  assign done      = (state_q == ST_DONE);

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R2
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) (mem_we || cap) |-> !req_ready);
  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));
  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) accept |=> !req_ready);
endmodule

// File: rtl/lsu_pack.sv
module lsu_pack
  import lsu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            cap,
  input  logic [1:0]      cap_idx,
  input  logic [7:0]      rbyte,
  input  logic            done,
  input  logic            store_q,
  input  logic [2:0]      code_q,
  output logic [XLEN-1:0] result
);
  logic [XLEN-1:0] asm_q;
  logic [XLEN-1:0] ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     asm_q <= '0;
    else if (clear) asm_q <= '0;
    else if (cap)   asm_q[cap_idx*8 +: 8] <= rbyte;
  end

  always_comb begin
    case (code_q)
      W_BYTE:   ext = {{(XLEN-8){asm_q[7]}}, asm_q[7:0]};
      W_HALF:   ext = {{(XLEN-16){asm_q[15]}}, asm_q[15:0]};
      W_WORD:   ext = asm_q;
      W_BYTE_U: ext = {{(XLEN-8){1'b0}}, asm_q[7:0]};
      W_HALF_U: ext = {{(XLEN-16){1'b0}}, asm_q[15:0]};
      default:  ext = '0;
    endcase
  end

  assign result = (done && !store_q) ? ext : '0;

  // R10
  store_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && store_q) |-> (result == '0));
endmodule

// File: rtl/lsu_byteserial.sv
module lsu_byteserial #(
  parameter int MEM_BYTES = 64,
  localparam int ADDR_W = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [2:0]        req_funct3,
  input  logic [31:0]       req_base,
  input  logic [11:0]       req_imm,
  input  logic [31:0]       req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              done,
  output logic [31:0]       result,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [7:0]        peek_data
);
  logic [ADDR_W-1:0] ea;
  logic              accept;
  logic              cap;
  logic [1:0]        cap_idx;
  logic              store_q;
  logic [2:0]        code_q;
  logic [2:0]        len_q;
  logic [7:0]        rbyte;

  lsu_agen #(.ADDR_W(ADDR_W), .IMM_W(12), .XLEN(32)) u_agen (
    .base(req_base), .imm(req_imm), .ea(ea)
  );

  lsu_ctrl #(.ADDR_W(ADDR_W), .XLEN(32)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_funct3(req_funct3), .req_wdata(req_wdata), .ea(ea),
    .req_ready(req_ready), .accept(accept), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wbyte(mem_wdata), .cap(cap), .cap_idx(cap_idx), .done(done),
    .store_q(store_q), .code_q(code_q), .len_q(len_q)
  );

  lsu_mem #(.MEM_BYTES(MEM_BYTES)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(mem_addr), .wbyte(mem_wdata),
    .rbyte(rbyte), .peek_addr(peek_addr), .peek_data(peek_data)
  );

  lsu_pack #(.XLEN(32)) u_pack (
    .clk(clk), .rst_n(rst_n), .clear(accept), .cap(cap), .cap_idx(cap_idx),
    .rbyte(rbyte), .done(done), .store_q(store_q), .code_q(code_q), .result(result)
  );

  // R8
  undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && len_q == 3'd0) |-> (result == 32'h0 && !mem_we));
  // R8
  undef_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && lsu_pkg::access_len(req_store, req_funct3) == 3'd0) |=> (done && !mem_we));
endmodule

// File: tb/sim_lsu_byteserial.sv
`timescale 1ns/1ps
module sim_lsu_byteserial;
  localparam int MB = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_store = 1'b0;
  logic [2:0]  req_funct3 = '0;
  logic [31:0] req_base = '0;
  logic [11:0] req_imm = '0;
  logic [31:0] req_wdata = '0;
  logic [5:0]  mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        done;
  logic [31:0] result;
  logic [5:0]  peek_addr = '0;
  logic [7:0]  peek_data;

  lsu_byteserial #(.MEM_BYTES(MB)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_funct3(req_funct3), .req_base(req_base),
    .req_imm(req_imm), .req_wdata(req_wdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .done(done), .result(result),
    .peek_addr(peek_addr), .peek_data(peek_data)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [31:0] res;
    int          len;
    int          due;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [7:0]  ref_mem [MB];
  int          cyc = 0;
  int          total = 0;
  int          bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int model_len(input logic st, input logic [2:0] f);
    if (st) return (f == 3'b000) ? 1 : (f == 3'b001) ? 2 : (f == 3'b010) ? 4 : 0;
    case (f)
      3'b000, 3'b100: return 1;
      3'b001, 3'b101: return 2;
      3'b010:         return 4;
      default:        return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as done pulses arrive
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R2 unexpected done", result, 32'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(result == e.res, e.tag, result, e.res);
        check(cyc == e.due, {e.tag, " R3 latency"}, cyc, e.due);
      end
    end
  end

  // driver: computes expected item from the model and queues it before the accepting edge
  task automatic issue(input logic st, input logic [2:0] f, input logic [31:0] base,
                       input logic [11:0] imm, input logic [31:0] wd, input string tag);
    exp_t        e;
    logic [31:0] ea32;
    logic [31:0] raw;
    int          n;
    int          a;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    ea32 = base + {{20{imm[11]}}, imm};
    n    = model_len(st, f);
    raw  = 32'h0;
    for (int i = 0; i < n; i++) begin
      a = int'((ea32 + 32'(i)) % MB);
      if (st) ref_mem[a] = wd[i*8 +: 8];
      else    raw[i*8 +: 8] = ref_mem[a];
    end
    if (st || n == 0) e.res = 32'h0;
    else begin
      case (f)
        3'b000:  e.res = {{24{raw[7]}}, raw[7:0]};
        3'b001:  e.res = {{16{raw[15]}}, raw[15:0]};
        3'b100:  e.res = {24'h0, raw[7:0]};
        3'b101:  e.res = {16'h0, raw[15:0]};
        default: e.res = raw;
      endcase
    end
    e.len = n;
    e.due = cyc + 1 + n;
    e.tag = tag;
    sb_q.push_back(e);
    req_valid = 1'b1; req_store = st; req_funct3 = f;
    req_base = base; req_imm = imm; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (sb_q.size() != 0 || !req_ready);
  endtask

  task automatic peek_chk(input int a, input string tag);
    peek_addr = 6'(a);
    #0.5;
    check(peek_data == ref_mem[a], tag, {24'h0, peek_data}, {24'h0, ref_mem[a]});
  endtask

  initial begin
    for (int i = 0; i < MB; i++) ref_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(req_ready == 1'b1, "R9 ready", {31'h0, req_ready}, 32'h1);
    check(done == 1'b0, "R9 done", {31'h0, done}, 32'h0);
    check(mem_we == 1'b0, "R9 we", {31'h0, mem_we}, 32'h0);
    peek_chk(5, "R9 mem zero");
    rst_n = 1'b1;

    // R4 R10 word store, then R5 word load
    issue(1'b1, 3'b010, 32'h10, 12'h000, 32'hF2345678, "R10 sw result");
    wait_idle();
    for (int i = 16; i < 21; i++) peek_chk(i, "R4 sw bytes");
    issue(1'b0, 3'b010, 32'h10, 12'h000, 32'h0, "R5 lw");
    // R6 signed, R7 unsigned
    issue(1'b0, 3'b000, 32'h13, 12'h000, 32'h0, "R6 lb neg");
    issue(1'b0, 3'b000, 32'h10, 12'h000, 32'h0, "R6 lb pos");
    issue(1'b0, 3'b001, 32'h12, 12'h000, 32'h0, "R6 lh neg");
    issue(1'b0, 3'b100, 32'h13, 12'h000, 32'h0, "R7 lbu");
    issue(1'b0, 3'b101, 32'h12, 12'h000, 32'h0, "R7 lhu");
    wait_idle();

    // R4 narrow stores leave neighbours untouched
    issue(1'b1, 3'b000, 32'h20, 12'h000, 32'h112233AB, "R10 sb result");
    issue(1'b1, 3'b001, 32'h24, 12'h000, 32'h5566C3D4, "R10 sh result");
    wait_idle();
    for (int i = 31; i < 40; i++) peek_chk(i, "R4 narrow store");
    issue(1'b0, 3'b001, 32'h24, 12'h000, 32'h0, "R6 lh after sh");

    // R1 negative offset and large base
    issue(1'b0, 3'b010, 32'h14, 12'hFFC, 32'h0, "R1 neg imm");
    issue(1'b0, 3'b010, 32'h12345610, 12'h000, 32'h0, "R1 base wraps");
    // R1 access crossing top of memory
    issue(1'b1, 3'b010, 32'h3E, 12'h000, 32'hA1B2C3D4, "R1 wrap store");
    wait_idle();
    peek_chk(62, "R1 wrap byte 62");
    peek_chk(0, "R1 wrap byte 0");
    peek_chk(1, "R1 wrap byte 1");
    issue(1'b0, 3'b010, 32'h40, 12'hFFE, 32'h0, "R1 wrap load");

    // R8 undefined codes
    issue(1'b0, 3'b011, 32'h10, 12'h000, 32'h0, "R8 load 011");
    issue(1'b0, 3'b111, 32'h10, 12'h000, 32'h0, "R8 load 111");
    issue(1'b1, 3'b100, 32'h08, 12'h000, 32'hFFFFFFFF, "R8 store 100");
    wait_idle();
    peek_chk(8, "R8 no write");

    // R2 request held while busy is ignored
    issue(1'b0, 3'b010, 32'h10, 12'h000, 32'h0, "R2 busy load");
    req_valid = 1'b1; req_store = 1'b1; req_funct3 = 3'b000;
    req_base = 32'h2A; req_imm = 12'h0; req_wdata = 32'h000000EE;
    @(negedge clk);
    check(req_ready == 1'b0, "R2 ready low busy", {31'h0, req_ready}, 32'h0);
    req_valid = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    peek_chk(42, "R2 ignored store");
    check(sb_q.size() == 0, "R2 queue drained", 32'(sb_q.size()), 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #50000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule